// File: doc/BRIEF.md
# Admin Command Queue Doorbell Engine

This engine runs on the device side of a host-managed administrative command channel. The host keeps a one-page array of equal-sized command slots in its own memory, places the page's number in a base register, fills slots, and then rings a doorbell with the running total of commands it has ever submitted. The engine compares that total with its own executed total. It works through the gap one command at a time: it reads the command word of the next slot, passes it to a small executor stub, writes a status word back into the same slot, and only then advances the executed total that the host polls.

Both totals are free-running counters that wrap to zero. A slot is picked by the low bits of the executed total, so the array is walked as a ring. Writing zero to the base register is the reset path. It clears both totals and stops the engine at once. A memory request that is already on the bus is allowed to finish, and no further memory traffic follows. Registers and in-memory words are big-endian by default.

Top module: `acq_engine`

## Requirements
- R1: With BIG_ENDIAN=1, the value written on reg_wdata is taken as big-endian: the register value is reg_wdata with its four bytes reversed. base_be, doorbell_be and executed_be give each register back in the same byte order, with counts zero-extended to 32 bits. reg_sel=0 selects the base page register and reg_sel=1 selects the doorbell.
- R2: A doorbell write whose value v gives a gap (v − executed) mod 2^COUNT_W that is zero or has its top bit set is ignored: the doorbell is unchanged and no memory access follows.
- R3: While the base register holds zero, doorbell writes are ignored and the engine makes no memory access.
- R4: Commands run strictly in order. Command number n reads slot n mod 2^(PAGE_SHIFT−SLOT_SHIFT) at byte address base·2^PAGE_SHIFT + slot·2^SLOT_SHIFT.
- R5: The command code is the first 32-bit word of the slot, read as big-endian. The status is 1 when the code is below NUM_OPS and 2 otherwise. It is written big-endian at byte offset STATUS_OFS of the same slot, and this is the only memory write the engine makes.
- R6: The executed count rises by one only after the status write is acknowledged. Processing stops when the executed count equals the doorbell value.
- R7: Both counts wrap modulo 2^COUNT_W, and the slot ring wraps with them.
- R8: Writing zero to the base register clears the doorbell and executed counts in the same cycle. An outstanding request is held until it is acknowledged. After that there is no new request, no further status write, and no count increment.
- R9: A memory request stays asserted, with stable address and direction, until mem_ack.
- R10: After reset all registers read zero, busy is low and mem_req is low. busy is low whenever the engine has no command in progress, and no request is raised while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: base page register, 1: doorbell |
| reg_wdata | input | 32 | Register write data, host byte order |
| base_be | output | 32 | Base page register, host byte order |
| doorbell_be | output | 32 | Doorbell count, host byte order |
| executed_be | output | 32 | Executed count, host byte order |
| busy | output | 1 | A command is in progress or a request is draining |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for the status write, 0 for the command fetch |
| mem_addr | output | PPN_W+PAGE_SHIFT | Byte address of the request |
| mem_wdata | output | 32 | Status word to write |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completion |

## Verification
The bound checker watches, on every cycle, the things that hold at any moment. Requests stay stable until acknowledged. Writes land only on the status word. The executed count moves only by one step after a status-write acknowledge, or back to zero, and it never runs past the doorbell. A zero base keeps both counts at zero and starts no request. The bench scenarios cover what needs a host model. They check the slot order across the ring and counter wraps, the status values decoded from big-endian command words, that backward, equal and zero-base doorbells are ignored, and that a reset in the middle of a batch drains a pending read and then goes quiet.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_EXEC,
      SQ_WB,
      SQ_DRAIN
   } sq_state_e;

   typedef enum logic {
      RSEL_BASE     = 1'b0,
      RSEL_DOORBELL = 1'b1
   } reg_sel_e;

   localparam logic [31:0] ST_DONE        = 32'h0000_0001;
   localparam logic [31:0] ST_UNSUPPORTED = 32'h0000_0002;

   function automatic logic [31:0] bswap32(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction
endpackage

// File: rtl/acq_regs.sv
module acq_regs
   import acq_pkg::*;
#(
   parameter int PPN_W      = 32,
   parameter int COUNT_W    = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic               reg_sel,
   input  logic [31:0]        reg_wdata,
   input  logic [COUNT_W-1:0] exec_cnt,
   output logic [PPN_W-1:0]   base_q,
   output logic [COUNT_W-1:0] db_q,
   output logic               abort,
   output logic [31:0]        base_be,
   output logic [31:0]        doorbell_be,
   output logic [31:0]        executed_be
);
   logic [31:0]        wr_val;
   logic [31:0]        base_ext;
   logic [31:0]        db_ext;
   logic [31:0]        ex_ext;
   logic [COUNT_W-1:0] db_new;
   logic [COUNT_W-1:0] db_gap;
   logic               base_wr;
   logic               db_wr;
   logic               db_take;

   always_comb begin
      base_ext = '0;
      base_ext[PPN_W-1:0] = base_q;
      db_ext = '0;
      db_ext[COUNT_W-1:0] = db_q;
      ex_ext = '0;
      ex_ext[COUNT_W-1:0] = exec_cnt;
   end

   generate
      if (BIG_ENDIAN) begin : g_big
         assign wr_val      = bswap32(reg_wdata);
         assign base_be     = bswap32(base_ext);
         assign doorbell_be = bswap32(db_ext);
         assign executed_be = bswap32(ex_ext);
      end else begin : g_little
         assign wr_val      = reg_wdata;
         assign base_be     = base_ext;
         assign doorbell_be = db_ext;
         assign executed_be = ex_ext;
      end
   endgenerate

   assign base_wr = reg_we && (reg_sel == RSEL_BASE);
   assign db_wr   = reg_we && (reg_sel == RSEL_DOORBELL);
   assign abort   = base_wr && (wr_val[PPN_W-1:0] == '0);
   assign db_new  = wr_val[COUNT_W-1:0];
   assign db_gap  = db_new - exec_cnt;
   assign db_take = db_wr && (base_q != '0) && (db_gap != '0) && !db_gap[COUNT_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         db_q   <= '0;
      end else begin
         if (base_wr) base_q <= wr_val[PPN_W-1:0];
         if (abort)        db_q <= '0;
         else if (db_take) db_q <= db_new;
      end
   end
endmodule

// File: rtl/acq_exec.sv
module acq_exec
   import acq_pkg::*;
#(
   parameter int NUM_OPS = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        op_valid,
   input  logic [31:0] op_code,
   output logic        st_valid,
   output logic [31:0] st_code
);
   localparam logic [31:0] OP_LIMIT = 32'(NUM_OPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_valid <= 1'b0;
         st_code  <= '0;
      end else begin
         st_valid <= op_valid;
         if (op_valid) st_code <= (op_code < OP_LIMIT) ? ST_DONE : ST_UNSUPPORTED;
      end
   end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_pkg::*;
#(
   parameter int PPN_W      = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int SLOT_SHIFT = 6,
   parameter int COUNT_W    = 32,
   parameter int STATUS_OFS = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int ADDR_W    = PPN_W + PAGE_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               abort,
   input  logic [PPN_W-1:0]   base_q,
   input  logic [COUNT_W-1:0] db_q,
   input  logic               st_valid,
   input  logic [31:0]        st_code,
   input  logic               mem_ack,
   input  logic [31:0]        mem_rdata,
   output logic [COUNT_W-1:0] exec_cnt,
   output logic               op_valid,
   output logic [31:0]        op_code,
   output logic               busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [31:0]        mem_wdata
);
   localparam int IDX_W = PAGE_SHIFT - SLOT_SHIFT;
   localparam logic [SLOT_SHIFT-1:0] ST_OFS = SLOT_SHIFT'(STATUS_OFS);

   sq_state_e          state_q;
   logic [COUNT_W-1:0] cnt_q;
   logic [IDX_W-1:0]   slot;
   logic [31:0]        wb_word;
   logic               pending;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign op_code = bswap32(mem_rdata);
         assign wb_word = bswap32(st_code);
      end else begin : g_little
         assign op_code = mem_rdata;
         assign wb_word = st_code;
      end
   endgenerate

   assign slot     = cnt_q[IDX_W-1:0];
   assign pending  = (base_q != '0) && (db_q != cnt_q);
   assign op_valid = (state_q == SQ_FETCH) && mem_ack && !abort;
   assign busy     = (state_q != SQ_IDLE);
   assign exec_cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         cnt_q     <= '0;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (pending && !abort) begin
                  mem_req  <= 1'b1;
                  mem_we   <= 1'b0;
                  mem_addr <= {base_q, slot, {SLOT_SHIFT{1'b0}}};
                  state_q  <= SQ_FETCH;
               end
            end
            SQ_FETCH: begin
               if (mem_ack) begin
                  mem_req <= 1'b0;
                  state_q <= abort ? SQ_IDLE : SQ_EXEC;
               end else if (abort) begin
                  state_q <= SQ_DRAIN;
               end
            end
            SQ_EXEC: begin
               if (abort) begin
                  state_q <= SQ_IDLE;
               end else if (st_valid) begin
                  mem_req   <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_addr  <= {base_q, slot, ST_OFS};
                  mem_wdata <= wb_word;
                  state_q   <= SQ_WB;
               end
            end
            SQ_WB: begin
               if (mem_ack) begin
                  mem_req <= 1'b0;
                  state_q <= SQ_IDLE;
                  cnt_q   <= cnt_q + 1'b1;
               end else if (abort) begin
                  state_q <= SQ_DRAIN;
               end
            end
            SQ_DRAIN: begin
               if (mem_ack) begin
                  mem_req <= 1'b0;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
         if (abort) cnt_q <= '0;
      end
   end
endmodule

// File: rtl/acq_engine.sv
module acq_engine
   import acq_pkg::*;
#(
   parameter int PPN_W      = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int SLOT_SHIFT = 6,
   parameter int COUNT_W    = 32,
   parameter int NUM_OPS    = 16,
   parameter int STATUS_OFS = 4,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic                        reg_sel,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 base_be,
   output logic [31:0]                 doorbell_be,
   output logic [31:0]                 executed_be,
   output logic                        busy,
   output logic                        mem_req,
   output logic                        mem_we,
   output logic [PPN_W+PAGE_SHIFT-1:0] mem_addr,
   output logic [31:0]                 mem_wdata,
   input  logic [31:0]                 mem_rdata,
   input  logic                        mem_ack
);
   localparam int IDX_W = PAGE_SHIFT - SLOT_SHIFT;

   if (SLOT_SHIFT < 3 || SLOT_SHIFT >= PAGE_SHIFT) begin : g_bad_slot
      $error("slot size must be at least 8 bytes and below one page");
   end
   if ((STATUS_OFS % 4) != 0 || STATUS_OFS < 4 || STATUS_OFS >= (1 << SLOT_SHIFT)) begin : g_bad_ofs
      $error("status offset must be word aligned, past the command word, inside a slot");
   end
   if (COUNT_W <= IDX_W || COUNT_W > 32) begin : g_bad_cnt
      $error("count width must exceed the slot index width and fit 32 bits");
   end
   if (PPN_W < 1 || PPN_W > 32 || NUM_OPS < 1) begin : g_bad_misc
      $error("page number width or opcode count out of range");
   end

   logic [PPN_W-1:0]   base_q;
   logic [COUNT_W-1:0] db_q;
   logic [COUNT_W-1:0] exec_cnt;
   logic               abort;
   logic               op_valid;
   logic [31:0]        op_code;
   logic               st_valid;
   logic [31:0]        st_code;

   acq_regs #(.PPN_W(PPN_W), .COUNT_W(COUNT_W), .BIG_ENDIAN(BIG_ENDIAN)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .exec_cnt(exec_cnt), .base_q(base_q), .db_q(db_q), .abort(abort),
      .base_be(base_be), .doorbell_be(doorbell_be), .executed_be(executed_be)
   );

   acq_seq #(
      .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT), .SLOT_SHIFT(SLOT_SHIFT),
      .COUNT_W(COUNT_W), .STATUS_OFS(STATUS_OFS), .BIG_ENDIAN(BIG_ENDIAN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .abort(abort), .base_q(base_q), .db_q(db_q),
      .st_valid(st_valid), .st_code(st_code), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .exec_cnt(exec_cnt), .op_valid(op_valid), .op_code(op_code), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   acq_exec #(.NUM_OPS(NUM_OPS)) u_exec (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .st_valid(st_valid), .st_code(st_code)
   );
endmodule

// File: rtl/acq_engine_chk.sv
module acq_engine_chk
   import acq_pkg::*;
#(
   parameter int PPN_W      = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int SLOT_SHIFT = 6,
   parameter int COUNT_W    = 32,
   parameter int STATUS_OFS = 4,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [31:0]                 base_be,
   input logic [31:0]                 doorbell_be,
   input logic [31:0]                 executed_be,
   input logic                        busy,
   input logic                        mem_req,
   input logic                        mem_we,
   input logic [PPN_W+PAGE_SHIFT-1:0] mem_addr,
   input logic                        mem_ack
);
   function automatic logic [31:0] to_host(input logic [31:0] v);
      return BIG_ENDIAN ? bswap32(v) : v;
   endfunction

   logic [31:0]        base_c;
   logic [31:0]        db_w;
   logic [31:0]        ex_w;
   logic [COUNT_W-1:0] db_c;
   logic [COUNT_W-1:0] ex_c;
   logic [COUNT_W-1:0] gap_c;

   assign base_c = to_host(base_be);
   assign db_w   = to_host(doorbell_be);
   assign ex_w   = to_host(executed_be);
   assign db_c   = db_w[COUNT_W-1:0];
   assign ex_c   = ex_w[COUNT_W-1:0];
   assign gap_c  = db_c - ex_c;

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
   AST_WRITE_AT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[SLOT_SHIFT-1:0] == SLOT_SHIFT'(STATUS_OFS))); // R5
   AST_COUNT_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      ((ex_c != $past(ex_c)) && (ex_c != '0)) |-> $past(mem_req && mem_we && mem_ack)); // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_c != $past(ex_c)) |-> ((ex_c == COUNT_W'($past(ex_c) + 1'b1)) || (ex_c == '0))); // R7
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      !gap_c[COUNT_W-1]); // R2
   AST_ZERO_BASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (base_c == '0) |-> ((ex_c == '0) && (db_c == '0))); // R3
   AST_NO_REQ_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (base_c != '0)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R10
endmodule

bind acq_engine acq_engine_chk #(
   .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT), .SLOT_SHIFT(SLOT_SHIFT),
   .COUNT_W(COUNT_W), .STATUS_OFS(STATUS_OFS), .BIG_ENDIAN(BIG_ENDIAN)
) u_chk (.*);

// File: tb/acq_engine_tb.sv
module acq_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PS = 8;
   localparam int SS = 5;
   localparam int CW = 8;
   localparam int NO = 4;
   localparam int SO = 4;
   localparam int PW = 16;
   localparam int AW = PW + PS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic          reg_sel = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   base_be, doorbell_be, executed_be;
   logic          busy, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic          mem_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int lat = 0;
   int lat_cnt = 0;
   int rd_seq = 0;
   int wr_seq = 0;
   int acc = 0;
   logic [15:0] cur_base = '0;
   logic [31:0] mem [0:127];

   always #(CLK_PERIOD/2) clk = ~clk;

   acq_engine #(.PPN_W(PW), .PAGE_SHIFT(PS), .SLOT_SHIFT(SS), .COUNT_W(CW),
                .NUM_OPS(NO), .STATUS_OFS(SO), .BIG_ENDIAN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .base_be(base_be), .doorbell_be(doorbell_be), .executed_be(executed_be), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   function automatic logic [31:0] sw(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction
   function automatic logic [31:0] cnt_be(input int v);
      return sw({24'h0, 8'(v)});
   endfunction
   function automatic logic [31:0] opc(input int n);
      if (n % 9 == 4) return 32'h0001_0002;
      return 32'((n * 5 + 3) % 7);
   endfunction
   function automatic logic [31:0] stat(input logic [31:0] op);
      return (op < 32'(NO)) ? 32'h1 : 32'h2;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // host memory model with variable latency; also checks every access
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt >= lat) begin
            lat_cnt <= 0;
            mem_ack <= 1'b1;
            acc <= acc + 1;
            if (mem_we) begin
               chk(mem_addr == {cur_base, 3'(wr_seq), 5'd4}, "R4 R5 status write address",
                   32'(mem_addr), 32'({cur_base, 3'(wr_seq), 5'd4}));
               chk(mem_wdata == sw(stat(sw(mem[{cur_base[0], 3'(wr_seq), 3'd0}]))), "R5 status value",
                   mem_wdata, sw(stat(sw(mem[{cur_base[0], 3'(wr_seq), 3'd0}]))));
               mem[{mem_addr[8], mem_addr[7:2]}] <= mem_wdata;
               wr_seq <= wr_seq + 1;
            end else begin
               chk(mem_addr == {cur_base, 3'(rd_seq), 5'd0}, "R4 fetch address",
                   32'(mem_addr), 32'({cur_base, 3'(rd_seq), 5'd0}));
               mem_rdata <= mem[{mem_addr[8], mem_addr[7:2]}];
               rd_seq <= rd_seq + 1;
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic reg_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1;
      reg_sel = sel;
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic host_put(input int n);
      mem[{cur_base[0], 3'(n), 3'd0}] = sw(opc(n));
      mem[{cur_base[0], 3'(n), 3'd1}] = 32'hDEAD_BEEF;
   endtask

   task automatic wait_exec(input int exp, input string rq);
      int guard = 0;
      while (sw(executed_be) != 32'(exp) && guard < 4000) begin
         @(negedge clk);
         guard++;
      end
      chk(sw(executed_be) == 32'(exp), rq, sw(executed_be), 32'(exp));
   endtask

   task automatic check_status(input int n);
      logic [31:0] got = mem[{cur_base[0], 3'(n), 3'd1}];
      chk(got == sw(stat(opc(n))), "R5 R6 stored status", got, sw(stat(opc(n))));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int total;
      int snap;
      int wsnap;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(base_be == 32'h0, "R10 base after reset", base_be, 32'h0);
      chk(doorbell_be == 32'h0, "R10 doorbell after reset", doorbell_be, 32'h0);
      chk(executed_be == 32'h0, "R10 executed after reset", executed_be, 32'h0);
      chk({busy, mem_req} == 2'b00, "R10 idle after reset", {30'h0, busy, mem_req}, 32'h0);

      // R3 doorbell ignored while base is zero
      reg_wr(1'b1, cnt_be(3));
      repeat (20) @(negedge clk);
      chk(doorbell_be == 32'h0, "R3 doorbell with zero base", doorbell_be, 32'h0);
      chk(acc == 0, "R3 no access with zero base", 32'(acc), 32'h0);

      // R1 base written big-endian and echoed
      cur_base = 16'h0001;
      reg_wr(1'b0, 32'h0100_0000);
      chk(base_be == 32'h0100_0000, "R1 base byte order", base_be, 32'h0100_0000);

      // first batch of three
      total = 0;
      for (int j = 0; j < 8; j++) host_put(j);
      reg_wr(1'b1, cnt_be(3));
      chk(doorbell_be == cnt_be(3), "R1 doorbell byte order", doorbell_be, cnt_be(3));
      wait_exec(3, "R6 first batch done");
      total = 3;
      for (int j = 0; j < 3; j++) check_status(j);
      chk(mem[{1'b1, 3'd3, 3'd1}] == 32'hDEAD_BEEF, "R6 slot past doorbell untouched",
          mem[{1'b1, 3'd3, 3'd1}], 32'hDEAD_BEEF);

      // R2 backward and equal doorbells ignored
      snap = acc;
      reg_wr(1'b1, cnt_be(2));
      chk(doorbell_be == cnt_be(3), "R2 backward doorbell", doorbell_be, cnt_be(3));
      reg_wr(1'b1, cnt_be(3 + 200));
      chk(doorbell_be == cnt_be(3), "R2 far doorbell", doorbell_be, cnt_be(3));
      reg_wr(1'b1, cnt_be(3));
      repeat (15) @(negedge clk);
      chk(acc == snap, "R2 no access after ignored doorbell", 32'(acc), 32'(snap));
      chk(busy == 1'b0, "R2 stays idle", {31'h0, busy}, 32'h0);

      // sweep batch sizes and latencies across slot and count wraps (R4, R7)
      for (int r = 0; r < 8; r++) begin
         for (int k = 1; k <= 8; k++) begin
            lat = (r + k) % 4;
            for (int j = 0; j < k; j++) host_put(total + j);
            reg_wr(1'b1, cnt_be(total + k));
            total += k;
            wait_exec(total % 256, "R7 batch executed count");
            chk(busy == 1'b0, "R10 idle after batch", {31'h0, busy}, 32'h0);
            for (int j = 0; j < k; j++) check_status(total - k + j);
         end
      end
      chk(total > 256, "R7 count wrapped", 32'(total), 32'd257);

      // R8 base reset in the middle of a batch
      lat = 3;
      snap = rd_seq;
      for (int j = 0; j < 5; j++) host_put(total + j);
      reg_wr(1'b1, cnt_be(total + 5));
      while (!(mem_req && !mem_we && rd_seq == snap + 1)) @(negedge clk);
      wsnap = wr_seq;
      reg_wr(1'b0, 32'h0);
      chk(executed_be == 32'h0, "R8 executed cleared", executed_be, 32'h0);
      chk(doorbell_be == 32'h0, "R8 doorbell cleared", doorbell_be, 32'h0);
      chk(base_be == 32'h0, "R8 base cleared", base_be, 32'h0);
      repeat (10) @(negedge clk);
      snap = acc;
      chk({busy, mem_req} == 2'b00, "R8 engine quiet after drain", {30'h0, busy, mem_req}, 32'h0);
      repeat (30) @(negedge clk);
      chk(acc == snap, "R8 no access after drain", 32'(acc), 32'(snap));
      chk(wr_seq == wsnap, "R8 no status write after reset", 32'(wr_seq), 32'(wsnap));
      chk(executed_be == 32'h0, "R8 executed still zero", executed_be, 32'h0);

      // restart on another page from slot zero
      rd_seq = 0;
      wr_seq = 0;
      cur_base = 16'h0002;
      lat = 1;
      for (int j = 0; j < 6; j++) host_put(j);
      reg_wr(1'b0, 32'h0200_0000);
      reg_wr(1'b1, cnt_be(6));
      wait_exec(6, "R8 restart after reset");
      for (int j = 0; j < 6; j++) check_status(j);

      repeat (5) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule